// File: doc/BRIEF.md
# Chained Packed-Decimal Byte Adder

This unit adds two multi-byte packed-decimal numbers held in memory, one byte at a time. Each byte carries a fixed number of decimal digits, two by default. A start pulse gives the byte count and an end address for each operand. The unit reads the source operand and the destination operand one byte pair at a time. It starts with the highest addresses, where the least-significant digit pair sits, and moves downward. Each sum is written back over the destination byte.

A decimal extend bit links the steps. The carry out of one byte becomes the carry in of the next. When the chain ends, the unit drives three flags: extend, carry and a zero flag. The zero flag stays set only if every result byte was zero, so one test after the chain shows whether the whole multi-byte result is zero.

The memory port is simple and synchronous. An address and a read strobe given in one cycle return data in the next cycle. The result byte goes out on a write strobe to the destination address of the same step.

Top module: `bcd_chain_adder`

## Requirements
- R1: A start pulse in idle with count N>0 and end addresses S and D causes exactly N reads. Step k (k=1..N) reads the source at S-k and the destination at D-k. Exactly one cycle later it writes the result to D-k with wrEn high.
- R2: Each digit (nibble, digit 0 in bits 3:0) is summed as t = a + b + carry-in. If t > 9, the digit result is (t+6) mod 16 and the carry to the next digit is 1. Otherwise the digit result is t and the carry is 0.
- R3: The carry out of the top digit of a byte sets both flagX and flagC. Its absence clears both. flagX is the carry into digit 0 of the next byte.
- R4: A start presets flagX=0, flagC=0 and flagZ=1. A non-zero result byte clears flagZ. A zero result byte leaves flagZ unchanged.
- R5: done is high for exactly one cycle, the cycle after the last write. From then until the next accepted start, the flags do not change.
- R6: A start with count 0 performs no read and no write. It raises done in the following cycle, with flagX=0, flagC=0 and flagZ=1.
- R7: A start pulse while busy is high is ignored. The running chain keeps its addresses, writes and flags.
- R8: Digits above 9 are not flagged. They follow the R2 rule, so source 0xFF plus destination 0x00 with carry-in 0 gives 0x65 and a carry.
- R9: After reset, busy, done, rdEn and wrEn are low. busy is high from the cycle after an accepted start through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain (accepted when idle) |
| byteCount | input | CNT_W | Number of bytes in the chain |
| srcEnd | input | ADDR_W | One past the source's least-significant byte |
| dstEnd | input | ADDR_W | One past the destination's least-significant byte |
| rdEn | output | 1 | Read strobe for both operand bytes |
| srcAddr | output | ADDR_W | Source byte address |
| dstAddr | output | ADDR_W | Destination byte address (read and write) |
| srcData | input | 4*DIGITS | Source byte, valid the cycle after rdEn |
| dstData | input | 4*DIGITS | Destination byte, valid the cycle after rdEn |
| wrEn | output | 1 | Result write strobe |
| wrData | output | 4*DIGITS | Result byte |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle completion pulse |
| flagX | output | 1 | Decimal extend |
| flagC | output | 1 | Decimal carry |
| flagZ | output | 1 | Sticky zero over the chain |

## Verification
The adder is driven with a single byte with no carry and with byte pairs whose sum ripples a carry through every byte (0x99 chains). These separate the per-digit correction from the propagation of the extend bit between bytes. Chains whose result bytes are zero because of a decimal carry (0x50+0x50) are compared with chains that hold one non-zero byte. This shows the zero flag is sticky and not just a copy of the last byte. Operands with invalid digits, a zero count and a start pulse given in the middle of a chain check the edge rules.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_ADD  = 2'd2,
    ST_FIN  = 2'd3
  } chainState_t;

  typedef struct packed {
    logic load;   // preset flags and pointers
    logic rdEn;   // operand fetch this cycle
    logic wrEn;   // fetched data is summed and stored this cycle
    logic done;   // completion pulse
  } chainCtl_t;

endpackage

// File: rtl/bcd_chain_ctrl.sv
module bcd_chain_ctrl
  import bcd_chain_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  output chainCtl_t        ctl,
  output logic             busy
);

  chainState_t       state;
  chainState_t       stateNext;
  logic [CNT_W-1:0]  remaining;
  logic              accept;

  assign accept = start && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = (byteCount == '0) ? ST_FIN : ST_READ;
      ST_READ: stateNext = ST_ADD;
      ST_ADD:  stateNext = (remaining == CNT_W'(1)) ? ST_FIN : ST_READ;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
    end else begin
      state <= stateNext;
      if (accept)
        remaining <= byteCount;
      else if (state == ST_ADD)
        remaining <= remaining - CNT_W'(1);
    end
  end

  always_comb begin
    ctl.load = accept;
    ctl.rdEn = (state == ST_READ);
    ctl.wrEn = (state == ST_ADD);
    ctl.done = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !ctl.done);

  // R6: empty chain finishes in the next cycle
  a_r6_empty_done: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && byteCount == '0) |=> (ctl.done && !ctl.rdEn && !ctl.wrEn));

  // R7: a start while running does not reload the counter
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && state == ST_READ) |=> (remaining == $past(remaining)));

endmodule

// File: rtl/bcd_chain_datapath.sv
module bcd_chain_datapath
  import bcd_chain_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIGITS = 2,
  localparam int DATA_W = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainCtl_t         ctl,
  input  logic [ADDR_W-1:0] srcEnd,
  input  logic [ADDR_W-1:0] dstEnd,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] dstData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] sumByte,
  output logic              flagX,
  output logic              flagC,
  output logic              flagZ
);

  logic [ADDR_W-1:0] srcPtr;
  logic [ADDR_W-1:0] dstPtr;
  logic [DIGITS:0]   digitCarry;

  assign digitCarry[0] = flagX;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [4:0] rawSum;
    logic       adjust;
    assign rawSum = {1'b0, srcData[4*g +: 4]} + {1'b0, dstData[4*g +: 4]}
                  + {4'd0, digitCarry[g]};
    assign adjust = (rawSum > 5'd9);
    assign sumByte[4*g +: 4] = rawSum[3:0] + (adjust ? 4'd6 : 4'd0);
    assign digitCarry[g+1]   = adjust;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
      flagX  <= 1'b0;
      flagC  <= 1'b0;
      flagZ  <= 1'b0;
    end else if (ctl.load) begin
      srcPtr <= srcEnd - ADDR_W'(1);
      dstPtr <= dstEnd - ADDR_W'(1);
      flagX  <= 1'b0;
      flagC  <= 1'b0;
      flagZ  <= 1'b1;
    end else if (ctl.wrEn) begin
      srcPtr <= srcPtr - ADDR_W'(1);
      dstPtr <= dstPtr - ADDR_W'(1);
      flagX  <= digitCarry[DIGITS];
      flagC  <= digitCarry[DIGITS];
      if (sumByte != '0) flagZ <= 1'b0;
    end
  end

  assign srcAddr = srcPtr;
  assign dstAddr = dstPtr;

  // R1: a write is always preceded by the fetch of its operands
  a_r1_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> $past(ctl.rdEn));

  // R4: zero flag can only be raised by a preset
  a_r4_zero_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagZ) |-> $past(ctl.load));

  // R5: flags frozen outside preset and add steps
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.wrEn) |=> $stable({flagX, flagC, flagZ}));

  // R1: addresses move only on a step or a preset
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.wrEn && !ctl.done) |=> $stable({srcPtr, dstPtr}));

endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
  import bcd_chain_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIGITS = 2,
  localparam int DATA_W = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [ADDR_W-1:0] srcEnd,
  input  logic [ADDR_W-1:0] dstEnd,
  output logic              rdEn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] dstData,
  output logic              wrEn,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              flagX,
  output logic              flagC,
  output logic              flagZ
);

  chainCtl_t ctl;

  bcd_chain_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .byteCount(byteCount),
    .ctl      (ctl),
    .busy     (busy)
  );

  bcd_chain_datapath #(.ADDR_W(ADDR_W), .DIGITS(DIGITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .srcEnd (srcEnd),
    .dstEnd (dstEnd),
    .srcData(srcData),
    .dstData(dstData),
    .srcAddr(srcAddr),
    .dstAddr(dstAddr),
    .sumByte(wrData),
    .flagX  (flagX),
    .flagC  (flagC),
    .flagZ  (flagZ)
  );

  assign rdEn = ctl.rdEn;
  assign wrEn = ctl.wrEn;
  assign done = ctl.done;

endmodule

// File: tb/bcd_chain_adder_tb.sv
module bcd_chain_adder_tb;

  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] data;
  } wrItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0]  byteCount = '0;
  logic [ADDR_W-1:0] srcEnd = '0, dstEnd = '0;
  logic rdEn, wrEn, busy, done, flagX, flagC, flagZ;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [7:0] srcData, dstData, wrData;

  logic [7:0] srcMem [256];
  logic [7:0] dstMem [256];

  int total = 0;
  int bad = 0;
  int readCount = 0;
  int writeCount = 0;
  wrItem_t expQ[$];

  always #10 clk = ~clk;

  bcd_chain_adder u_dut (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .srcEnd(srcEnd), .dstEnd(dstEnd), .rdEn(rdEn), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .srcData(srcData), .dstData(dstData), .wrEn(wrEn),
    .wrData(wrData), .busy(busy), .done(done), .flagX(flagX),
    .flagC(flagC), .flagZ(flagZ)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (rdEn) begin
      srcData <= srcMem[srcAddr];
      dstData <= dstMem[dstAddr];
    end
    if (wrEn) dstMem[dstAddr] <= wrData;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (rstN && rdEn) readCount++;
    if (rstN && wrEn) begin
      writeCount++;
      if (expQ.size() == 0) begin
        check("R1 unexpected write", {24'd0, dstAddr}, 32'hFFFF_FFFF);
      end else begin
        wrItem_t it;
        it = expQ.pop_front();
        check("R1 write addr", {24'd0, dstAddr}, {24'd0, it.addr});
        check("R2 write data", {24'd0, wrData}, {24'd0, it.data});
      end
    end
  end

  // independent model of one byte step (R2, R3, R8)
  function automatic logic [8:0] refByte(input logic [7:0] a, input logic [7:0] b, input logic cin);
    int t;
    logic c;
    logic [7:0] r;
    c = cin;
    for (int d = 0; d < 2; d++) begin
      t = int'(a[4*d +: 4]) + int'(b[4*d +: 4]) + int'(c);
      if (t > 9) begin
        t = t + 6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*d +: 4] = 4'(t);
    end
    return {c, r};
  endfunction

  // driver: computes expectations, pushes them and runs one chain
  task automatic runChain(input string tag, input int n, input logic [7:0] sEnd,
                          input logic [7:0] dEnd, input bit midStart);
    logic x = 1'b0;
    logic z = 1'b1;
    logic [8:0] st;
    int guard = 0;
    int r0 = readCount;
    int w0 = writeCount;
    for (int k = 1; k <= n; k++) begin
      wrItem_t it;
      st = refByte(srcMem[8'(sEnd - k)], dstMem[8'(dEnd - k)], x);
      x = st[8];
      if (st[7:0] != 8'd0) z = 1'b0;
      it.addr = 8'(dEnd - k);
      it.data = st[7:0];
      expQ.push_back(it);
    end
    @(negedge clk);
    byteCount = CNT_W'(n);
    srcEnd = sEnd;
    dstEnd = dEnd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R9 busy after start"}, {31'd0, busy}, 32'd1);
    if (midStart) begin
      @(negedge clk);
      byteCount = 8'd1;
      srcEnd = 8'h10;
      dstEnd = 8'h20;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " R5 done seen"}, {31'd0, done}, 32'd1);
    check({tag, " R3 flagX"}, {31'd0, flagX}, {31'd0, x});
    check({tag, " R3 flagC"}, {31'd0, flagC}, {31'd0, x});
    check({tag, " R4 flagZ"}, {31'd0, flagZ}, {31'd0, z});
    check({tag, " R1 read count"}, 32'(readCount - r0), 32'(n));
    check({tag, " R1 write count"}, 32'(writeCount - w0), 32'(n));
    check({tag, " R1 queue drained"}, 32'(expQ.size()), 32'd0);
    @(negedge clk);
    check({tag, " R5 done one cycle"}, {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    check({tag, " R5 flags held"}, {29'd0, flagX, flagC, flagZ}, {29'd0, x, x, z});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      srcMem[i] = 8'h00;
      dstMem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    check("R9 reset busy", {31'd0, busy}, 32'd0);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R9 reset strobes", {30'd0, rdEn, wrEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: single byte, no carries
    srcMem[8'h40] = 8'h45; dstMem[8'h80] = 8'h38;
    runChain("single", 1, 8'h41, 8'h81, 1'b0);
    check("R2 stored 45+38", {24'd0, dstMem[8'h80]}, 32'h83);

    // R3: carry ripples through three bytes
    srcMem[8'h40] = 8'h99; srcMem[8'h41] = 8'h99; srcMem[8'h42] = 8'h99;
    dstMem[8'h80] = 8'h00; dstMem[8'h81] = 8'h00; dstMem[8'h82] = 8'h01;
    runChain("ripple", 3, 8'h43, 8'h83, 1'b0);

    // R4: zero bytes produced by decimal carry keep Z set
    srcMem[8'h40] = 8'h50; srcMem[8'h41] = 8'h50;
    dstMem[8'h80] = 8'h49; dstMem[8'h81] = 8'h50;
    runChain("zero", 2, 8'h42, 8'h82, 1'b0);

    // R4: one non-zero byte in the middle clears Z
    srcMem[8'h40] = 8'h00; srcMem[8'h41] = 8'h12; srcMem[8'h42] = 8'h00;
    dstMem[8'h80] = 8'h00; dstMem[8'h81] = 8'h00; dstMem[8'h82] = 8'h00;
    runChain("nonzero", 3, 8'h43, 8'h83, 1'b0);

    // R8: invalid digits follow the correction rule
    srcMem[8'h40] = 8'hFF; dstMem[8'h80] = 8'h00;
    runChain("invalid", 1, 8'h41, 8'h81, 1'b0);
    check("R8 FF+00", {24'd0, dstMem[8'h80]}, 32'h65);

    // R6: empty chain
    runChain("empty", 0, 8'h41, 8'h81, 1'b0);

    // R7: start during a run is ignored
    for (int i = 0; i < 5; i++) begin
      srcMem[8'h30 + i] = 8'(8'h11 * (i + 3));
      dstMem[8'h90 + i] = 8'(8'h22 + i);
    end
    runChain("R7 midstart", 5, 8'h35, 8'h95, 1'b1);

    // R1: address wrap across zero
    srcMem[8'h00] = 8'h27; srcMem[8'hFF] = 8'h88;
    dstMem[8'h01] = 8'h72; dstMem[8'h00] = 8'h19;
    runChain("wrap", 2, 8'h01, 8'h02, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule